// File: doc/BRIEF.md
# Converter Output Register with Overrange Saturation

This block is the last digital stage of a 10-bit converter. Each cycle the converter core may offer a new unsigned result together with an overrange flag and a load pulse. On the rising clock edge that sees the load pulse, the block captures the word into its output register and raises a one-cycle valid strobe. The data word is plain straight binary: a zero input gives all zeros and full scale gives all ones. While the overrange flag is set, the data word is forced to all ones whatever code the core supplied.

The data pins and the overrange pin share a high-impedance control. When the active-high disable input is set, the block deasserts a drive-enable signal and releases those pins to `z`. The output register itself keeps capturing new words while the pins are released, so the latest word appears as soon as the pins are driven again. The valid strobe is never released.

Top module: `adc_out_stage`

## Requirements
- R1: A low `rst_n` sampled on a rising edge clears the data register, the overrange register and `word_valid` to 0 after that edge.
- R2: On a rising edge with `core_load` high and `core_ovr` low, the data word becomes `core_code` unchanged (straight binary: 0 stays 0x000, 0x3FF stays 0x3FF).
- R3: On a rising edge with `core_load` high, the overrange output bit takes the value of `core_ovr`.
- R4: On a rising edge with `core_load` and `core_ovr` both high, the data word becomes 0x3FF for any `core_code`, and it stays 0x3FF for as long as the overrange bit stays 1.
- R5: On a rising edge with `core_load` low, the data word and the overrange bit keep their values.
- R6: `word_valid` is 1 during exactly the cycle after a rising edge that captured a word, and 0 after an edge without `core_load`.
- R7: While `out_hiz` is 1, `pin_drive_en` is 0 and `pin_word` and `pin_ovr` are released to `z`; while it is 0, `pin_drive_en` is 1 and the pins show the registered word and overrange bit.
- R8: Words captured while `out_hiz` is 1 are not lost: once the pins are driven again, they show the last word captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| core_code | input | 10 | Unsigned result from the converter core |
| core_ovr | input | 1 | Overrange flag from the converter core |
| core_load | input | 1 | Capture request for the current result |
| out_hiz | input | 1 | High puts the data and overrange pins into high impedance |
| pin_word | output | 10 | Registered straight-binary data word, tri-state |
| pin_ovr | output | 1 | Registered overrange bit, tri-state |
| pin_drive_en | output | 1 | High while the tri-state pins are driven |
| word_valid | output | 1 | One-cycle strobe marking a newly captured word |

## Verification
The assertions assume that `core_code`, `core_ovr`, `core_load` and `out_hiz` are known values at every rising edge once reset is released, and that the core may raise the overrange flag together with any code, including codes below full scale. The stimulus drives every input only on the falling edge, draws codes over the full 10-bit range with extra weight on 0 and 0x3FF, and sets the overrange flag with several unrelated codes so the saturation path is exercised apart from a natural full-scale code.

// File: rtl/adc_out_pkg.sv
// Package adc_out_pkg
// Shared types for the converter output stage: the width of the
// result word and the state of the tri-state pin drivers.
// Assumes nothing beyond the default result width of ten bits.
package adc_out_pkg;

    // Default width of the converter result word
    localparam int unsigned CODE_W_DEF = 10;

    // Drive state of the shared tri-state pins
    typedef enum logic {
        PINS_RELEASED = 1'b0,
        PINS_DRIVEN   = 1'b1
    } pin_drive_e;

    // Flags captured alongside the data word
    typedef struct packed {
        logic ovr;
        logic vld;
    } out_flags_t;

endpackage

// File: rtl/adc_sat_map.sv
// Module adc_sat_map
// Maps a raw converter result to the straight-binary output word.
// With the overrange flag clear the code passes unchanged; with it
// set every bit of the word is forced to one.
// Assumes the core reports overrange separately from the code.
module adc_sat_map #(
    parameter int unsigned W = adc_out_pkg::CODE_W_DEF
) (
    input  logic [W-1:0] raw_code,
    input  logic         raw_ovr,
    output logic [W-1:0] mapped_code
);

    localparam logic [W-1:0] FULL_SCALE = {W{1'b1}};

    // Saturate the word to full scale while overrange is flagged
    always_comb begin
        if (raw_ovr) begin
            mapped_code = FULL_SCALE;
        end else begin
            mapped_code = raw_code;
        end
    end

endmodule

// File: rtl/adc_word_reg.sv
// Module adc_word_reg
// Output register for the data word, the overrange bit and the
// valid strobe. Captures on the rising edge when load is high and
// holds otherwise. The strobe is high for one cycle per capture.
// Assumes a synchronous active-low reset.
module adc_word_reg #(
    parameter int unsigned W = adc_out_pkg::CODE_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [W-1:0]             word_d,
    input  logic                     ovr_d,
    output logic [W-1:0]             word_q,
    output adc_out_pkg::out_flags_t  flags_q
);

    // Capture or hold the data word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_d;
        end
    end

    // Capture or hold the overrange bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q.ovr <= 1'b0;
        end else if (load) begin
            flags_q.ovr <= ovr_d;
        end
    end

    // Pulse the valid strobe for the cycle after each capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q.vld <= 1'b0;
        end else begin
            flags_q.vld <= load;
        end
    end

endmodule

// File: rtl/adc_pin_drv.sv
// Module adc_pin_drv
// Per-bit tri-state drivers for a group of output pins. Each pin
// shows its data bit while enabled and is released to z otherwise.
// Assumes the enable is shared by the whole group.
module adc_pin_drv #(
    parameter int unsigned N = 11
) (
    input  logic [N-1:0]            bits_in,
    input  adc_out_pkg::pin_drive_e drive,
    output logic [N-1:0]            pins_out
);

    // One tri-state buffer per pin
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign pins_out[i] = (drive == adc_out_pkg::PINS_DRIVEN) ? bits_in[i] : 1'bz;
    end

endmodule

// File: rtl/adc_out_stage.sv
// Module adc_out_stage
// Output stage of a converter: saturates the result while overrange
// is flagged, registers word and flag on load, strobes valid for one
// cycle and drives the word and flag pins through tri-state buffers
// controlled by an active-high release input.
// Assumes inputs are synchronous to clk; the release path is
// combinational so the pins respond without a clock edge.
module adc_out_stage #(
    parameter int unsigned W = adc_out_pkg::CODE_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] core_code,
    input  logic         core_ovr,
    input  logic         core_load,
    input  logic         out_hiz,
    output logic [W-1:0] pin_word,
    output logic         pin_ovr,
    output logic         pin_drive_en,
    output logic         word_valid
);

    localparam int unsigned PIN_N = W + 1;

    logic [W-1:0]             sat_code;
    logic [W-1:0]             word_q;
    adc_out_pkg::out_flags_t  flags_q;
    adc_out_pkg::pin_drive_e  drive;
    logic [PIN_N-1:0]         pin_bus;
    logic                     ovr_q;

    adc_sat_map #(.W(W)) sat_i (
        .raw_code    (core_code),
        .raw_ovr     (core_ovr),
        .mapped_code (sat_code)
    );

    adc_word_reg #(.W(W)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (core_load),
        .word_d  (sat_code),
        .ovr_d   (core_ovr),
        .word_q  (word_q),
        .flags_q (flags_q)
    );

    // Select the pin drive state from the release input
    always_comb begin
        if (out_hiz) begin
            drive = adc_out_pkg::PINS_RELEASED;
        end else begin
            drive = adc_out_pkg::PINS_DRIVEN;
        end
    end

    assign ovr_q = flags_q.ovr;

    adc_pin_drv #(.N(PIN_N)) drv_i (
        .bits_in  ({ovr_q, word_q}),
        .drive    (drive),
        .pins_out (pin_bus)
    );

    assign pin_word     = pin_bus[W-1:0];
    assign pin_ovr      = pin_bus[W];
    assign pin_drive_en = (drive == adc_out_pkg::PINS_DRIVEN);
    assign word_valid   = flags_q.vld;

endmodule

// File: rtl/adc_out_stage_chk.sv
// Module adc_out_stage_chk
// Temporal checks on the output stage, bound to every instance.
// Assumes inputs are known at each rising edge after reset.
module adc_out_stage_chk #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] core_code,
    input  logic         core_ovr,
    input  logic         core_load,
    input  logic         out_hiz,
    input  logic [W-1:0] word_q,
    input  logic         ovr_q,
    input  logic         vld_q,
    input  logic         drive_en
);

    // R2
    straight_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_load && !core_ovr) |=> (word_q == $past(core_code)));

    // R3
    ovr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |=> (ovr_q == $past(core_ovr)));

    // R4
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> (word_q == {W{1'b1}}));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_load |=> ($stable(word_q) && $stable(ovr_q)));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |=> vld_q);

    // R6
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_load |=> !vld_q);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hiz |-> !drive_en);

endmodule

bind adc_out_stage adc_out_stage_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_code (core_code),
    .core_ovr  (core_ovr),
    .core_load (core_load),
    .out_hiz   (out_hiz),
    .word_q    (word_q),
    .ovr_q     (ovr_q),
    .vld_q     (word_valid),
    .drive_en  (pin_drive_en)
);

// File: tb/adc_out_stage_tb_top.sv
// Bench for adc_out_stage: directed corners plus seeded random
// stimulus, compared each falling edge against a bench model.
module adc_out_stage_tb_top;

    localparam int unsigned W = 10;
    localparam logic [W-1:0] FS = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] core_code = '0;
    logic         core_ovr = 1'b0;
    logic         core_load = 1'b0;
    logic         out_hiz = 1'b0;
    logic [W-1:0] pin_word;
    logic         pin_ovr;
    logic         pin_drive_en;
    logic         word_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Bench model state
    logic [W-1:0] m_word = '0;
    logic         m_ovr = 1'b0;
    logic         m_vld = 1'b0;

    always #10 clk = ~clk;

    adc_out_stage #(.W(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_code    (core_code),
        .core_ovr     (core_ovr),
        .core_load    (core_load),
        .out_hiz      (out_hiz),
        .pin_word     (pin_word),
        .pin_ovr      (pin_ovr),
        .pin_drive_en (pin_drive_en),
        .word_valid   (word_valid)
    );

    function automatic logic [W-1:0] exp_word(input logic [W-1:0] c, input logic o);
        return o ? FS : c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, then check at the next
    task automatic cyc(input logic rn, input logic [W-1:0] c, input logic o,
                       input logic ld, input logic hz);
        rst_n = rn; core_code = c; core_ovr = o; core_load = ld; out_hiz = hz;
        @(negedge clk);
        if (!rn) begin
            m_word = '0; m_ovr = 1'b0; m_vld = 1'b0;
        end else begin
            if (ld) begin
                m_word = exp_word(c, o);
                m_ovr = o;
            end
            m_vld = ld;
        end
        check("R6 valid", {31'd0, word_valid}, {31'd0, m_vld});
        check("R7 drive enable", {31'd0, pin_drive_en}, {31'd0, !hz});
        if (!hz) begin
            check("R2/R4/R5/R8 word", {22'd0, pin_word}, {22'd0, m_word});
            check("R3 ovr", {31'd0, pin_ovr}, {31'd0, m_ovr});
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0a3c));
        @(negedge clk);
        // R1 reset state
        cyc(1'b0, 10'h155, 1'b1, 1'b1, 1'b0);
        check("R1 reset word", {22'd0, pin_word}, 32'd0);
        check("R1 reset ovr", {31'd0, pin_ovr}, 32'd0);
        check("R1 reset valid", {31'd0, word_valid}, 32'd0);
        // R2 zero and full scale
        cyc(1'b1, 10'h000, 1'b0, 1'b1, 1'b0);
        check("R2 zero", {22'd0, pin_word}, 32'h000);
        cyc(1'b1, FS, 1'b0, 1'b1, 1'b0);
        check("R2 full scale", {22'd0, pin_word}, 32'h3FF);
        // R4 saturation with small code, held while ovr
        cyc(1'b1, 10'h001, 1'b1, 1'b1, 1'b0);
        check("R4 saturate", {22'd0, pin_word}, 32'h3FF);
        check("R3 ovr set", {31'd0, pin_ovr}, 32'd1);
        cyc(1'b1, 10'h000, 1'b0, 1'b0, 1'b0);
        check("R5 hold saturated", {22'd0, pin_word}, 32'h3FF);
        check("R6 no load", {31'd0, word_valid}, 32'd0);
        cyc(1'b1, 10'h2A5, 1'b0, 1'b1, 1'b0);
        check("R3 ovr cleared", {31'd0, pin_ovr}, 32'd0);
        check("R2 code after ovr", {22'd0, pin_word}, 32'h2A5);
        // R7/R8 capture while released
        cyc(1'b1, 10'h0F0, 1'b0, 1'b1, 1'b1);
        check("R7 released", {31'd0, pin_drive_en}, 32'd0);
        cyc(1'b1, 10'h11B, 1'b0, 1'b1, 1'b1);
        cyc(1'b1, 10'h000, 1'b0, 1'b0, 1'b0);
        check("R8 last word", {22'd0, pin_word}, 32'h11B);
        // Random phase
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] c;
            int sel;
            sel = int'($urandom_range(0, 9));
            c = (sel == 0) ? '0 : (sel == 1) ? FS : W'($urandom);
            cyc(($urandom_range(0, 49) != 0), c, ($urandom_range(0, 5) == 0),
                ($urandom_range(0, 9) < 7), ($urandom_range(0, 4) == 0));
        end
        // R1 reset mid-run
        cyc(1'b1, 10'h3C3, 1'b1, 1'b1, 1'b0);
        cyc(1'b0, 10'h3C3, 1'b1, 1'b1, 1'b0);
        check("R1 mid-run reset", {22'd0, pin_word}, 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule